// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that a small 16-bit processor uses to take a device interrupt and, later, to leave the service routine. Between instructions it decides whether a pending request may interrupt the running program. If it may, the block switches to the supervisor stack when the program was in user mode and pushes the untouched status word and then the program counter. It then reads the new program counter from a vector table at a fixed base. At the end it hands the processor a new status word with privilege set, the device priority installed and the condition codes cleared.

When the processor decodes the return instruction, it strobes the block. The block pops the program counter and then the status word. If the restored status word says user mode, it parks the supervisor pointer and brings back the user stack pointer. The block holds the two saved stack pointers itself. It drives one single-port memory interface that can stall any access. It hands all register results to the processor in a single commit cycle. The processor stays stalled while `busy` is high.

Top module: `intr_sequencer`

## Requirements
- R1: A request is accepted, and `irq_taken` pulses, only in a cycle where `irq_req`, `irq_en` and `insn_done` are all high and `irq_prio` is strictly greater than `psr_in[10:8]`. Otherwise no sequence starts and `busy` stays low.
- R2: On entry the committed status word has bit 15 cleared (privileged, where 1 means user), bits 10:8 equal to the device priority, bits 2:0 cleared, and every other bit copied from the status word at acceptance.
- R3: On entry from user mode (`psr_in[15]`=1) the saved user pointer takes the value of `sp_in`, and the stack used is the saved supervisor pointer. From privileged mode `sp_in` is used as is and the saved user pointer is untouched.
- R4: Entry writes the unmodified status word to address S-1 and then the program counter to S-2, where S is the stack pointer selected under R3. The committed R6 is S-2.
- R5: On entry the committed program counter is the word read from address 0x0100 plus the 8-bit `irq_vec`.
- R6: A `rti_start` strobe in idle reads the program counter from address R6, then the status word from R6+1. Both are committed, and the stack pointer ends at R6+2.
- R7: On return, if the popped status word has bit 15 set, the saved supervisor pointer takes the popped-up stack pointer and the committed R6 is the saved user pointer. Otherwise the committed R6 is the popped-up pointer and the saved supervisor pointer is unchanged.
- R8: Each memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_rdy` is seen high, and then advances. With L wait cycles per access, entry commits 3(L+1) cycles after acceptance and return commits 2(L+1) cycles after the strobe.
- R9: Results are presented in one cycle with `commit` high. `busy` is high from the cycle after acceptance through the commit cycle and low the cycle after.
- R10: After reset the block is idle with no memory request, the saved user pointer is 0 and the saved supervisor pointer is `SSP_RESET`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Device requests service |
| irq_en | input | 1 | Device interrupt enable |
| irq_prio | input | 3 | Device priority |
| irq_vec | input | 8 | Device vector index |
| insn_done | input | 1 | Current instruction has finished |
| rti_start | input | 1 | Return instruction decoded |
| psr_in | input | 16 | Current status word |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current R6 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rdy | input | 1 | Memory access completes this cycle |
| busy | output | 1 | Sequence in progress, processor stalled |
| irq_taken | output | 1 | Interrupt accepted this cycle |
| commit | output | 1 | Write the three result values this cycle |
| psr_out | output | 16 | Status word to write |
| pc_out | output | 16 | Program counter to write |
| sp_out | output | 16 | R6 value to write |
| usp_out | output | 16 | Saved user stack pointer |
| ssp_out | output | 16 | Saved supervisor stack pointer |

## Verification
Several properties hold on every cycle. The memory request holds still while the memory stalls, and a sequence starts only after an acceptance or a return strobe. An accepted interrupt begins with a write, and every commit is followed by idle. The bench scenarios show the rest. These are the acceptance rule across each of its conditions, and the exact status word, stack contents, vector word and pointer swaps for user and privileged entry. They also cover the matching return and the cycle counts under zero to three wait states.

// File: rtl/intr_sequencer.sv
module intr_sequencer #(
  parameter logic [15:0] VEC_BASE  = 16'h0100,
  parameter logic [15:0] SSP_RESET = 16'h3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic        irq_en,
  input  logic [2:0]  irq_prio,
  input  logic [7:0]  irq_vec,
  input  logic        insn_done,
  input  logic        rti_start,
  input  logic [15:0] psr_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_rdy,
  output logic        busy,
  output logic        irq_taken,
  output logic        commit,
  output logic [15:0] psr_out,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic [15:0] usp_out,
  output logic [15:0] ssp_out
);

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PSR, S_PUSH_PC, S_VEC, S_POP_PC, S_POP_PSR, S_DONE
  } st_t;

  st_t         st;
  logic        ret_q;
  logic [15:0] psr_q, pc_q, sp_q, usp_q, ssp_q;
  logic [7:0]  vec_q;
  logic [2:0]  prio_q;
  logic        accept;

  assign accept    = irq_req && irq_en && insn_done && (irq_prio > psr_in[10:8]);
  assign irq_taken = (st == S_IDLE) && !rti_start && accept;
  assign busy      = (st != S_IDLE);
  assign commit    = (st == S_DONE);
  assign usp_out   = usp_q;
  assign ssp_out   = ssp_q;

  assign mem_req   = (st == S_PUSH_PSR) || (st == S_PUSH_PC) || (st == S_VEC) ||
                     (st == S_POP_PC)   || (st == S_POP_PSR);
  assign mem_we    = (st == S_PUSH_PSR) || (st == S_PUSH_PC);
  assign mem_wdata = (st == S_PUSH_PSR) ? psr_q : pc_q;

  always_comb begin
    case (st)
      S_PUSH_PSR, S_PUSH_PC: mem_addr = sp_q - 16'd1;
      S_VEC:                 mem_addr = VEC_BASE + {8'h00, vec_q};
      default:               mem_addr = sp_q;
    endcase
  end

  assign psr_out = ret_q ? psr_q : {1'b0, psr_q[14:11], prio_q, psr_q[7:3], 3'b000};
  assign pc_out  = pc_q;
  assign sp_out  = (ret_q && psr_q[15]) ? usp_q : sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ret_q  <= 1'b0;
      psr_q  <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      vec_q  <= '0;
      prio_q <= '0;
      usp_q  <= '0;
      ssp_q  <= SSP_RESET;
    end else begin
      case (st)
        S_IDLE: begin
          if (rti_start) begin
            ret_q <= 1'b1;
            sp_q  <= sp_in;
            st    <= S_POP_PC;
          end else if (accept) begin
            ret_q  <= 1'b0;
            psr_q  <= psr_in;
            pc_q   <= pc_in;
            prio_q <= irq_prio;
            vec_q  <= irq_vec;
            if (psr_in[15]) begin
              usp_q <= sp_in;
              sp_q  <= ssp_q;
            end else begin
              sp_q  <= sp_in;
            end
            st <= S_PUSH_PSR;
          end
        end
        S_PUSH_PSR: if (mem_rdy) begin
          sp_q <= sp_q - 16'd1;
          st   <= S_PUSH_PC;
        end
        S_PUSH_PC: if (mem_rdy) begin
          sp_q <= sp_q - 16'd1;
          st   <= S_VEC;
        end
        S_VEC: if (mem_rdy) begin
          pc_q <= mem_rdata;
          st   <= S_DONE;
        end
        S_POP_PC: if (mem_rdy) begin
          pc_q <= mem_rdata;
          sp_q <= sp_q + 16'd1;
          st   <= S_POP_PSR;
        end
        S_POP_PSR: if (mem_rdy) begin
          psr_q <= mem_rdata;
          sp_q  <= sp_q + 16'd1;
          st    <= S_DONE;
        end
        S_DONE: begin
          if (ret_q && psr_q[15]) ssp_q <= sp_q;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  // R4
  entry_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |=> (mem_req && mem_we));

  // R1
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(irq_taken || rti_start));

endmodule

// File: tb/intr_sequencer_bench.sv
module intr_sequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic irq_req = 0, irq_en = 0, insn_done = 0, rti_start = 0;
  logic [2:0]  irq_prio = 0;
  logic [7:0]  irq_vec = 0;
  logic [15:0] psr_r = 0, pc_r = 0, r6_r = 0;
  logic        mem_req, mem_we, mem_rdy, busy, irq_taken, commit;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, psr_out, pc_out, sp_out, usp_out, ssp_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_sequencer u_intr_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .irq_prio(irq_prio), .irq_vec(irq_vec), .insn_done(insn_done),
    .rti_start(rti_start), .psr_in(psr_r), .pc_in(pc_r), .sp_in(r6_r),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .irq_taken(irq_taken), .commit(commit), .psr_out(psr_out),
    .pc_out(pc_out), .sp_out(sp_out), .usp_out(usp_out), .ssp_out(ssp_out));

  logic [15:0] mem [0:1023];
  int lat = 0;
  int wcnt = 0;
  int ntake = 0;
  int nchk = 0;
  int nfail = 0;
  logic rdy_r = 0;
  logic [15:0] rd_r = 0;
  assign mem_rdy = rdy_r;
  assign mem_rdata = rd_r;

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == lat) begin
        rdy_r <= 1'b1;
        wcnt  <= 0;
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        else if (mem_addr[15:8] == 8'h01) rd_r <= 16'h1000 | {8'h00, mem_addr[7:0]};
        else rd_r <= mem[mem_addr[9:0]];
      end else begin
        rdy_r <= 1'b0;
        wcnt  <= wcnt + 1;
      end
    end else begin
      rdy_r <= 1'b0;
      wcnt  <= 0;
    end
  end

  always @(posedge clk) if (irq_taken) ntake <= ntake + 1;

  typedef struct packed {
    logic [15:0] psr;
    logic [15:0] pc;
    logic [15:0] r6;
    logic [2:0]  prio;
    logic [7:0]  vec;
    logic        req;
    logic        en;
    logic        done;
    logic [1:0]  lat;
    logic        take;
  } case_t;

  localparam case_t TBL [8] = '{
    '{16'h8002, 16'h3010, 16'hFDF0, 3'd4, 8'h80, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
    '{16'h8002, 16'h3010, 16'hFDF0, 3'd4, 8'h80, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0},
    '{16'h8402, 16'h3020, 16'hFDF0, 3'd4, 8'h11, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0},
    '{16'h0201, 16'h0600, 16'h2F00, 3'd5, 8'h01, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1},
    '{16'hC37D, 16'h4123, 16'hF000, 3'd7, 8'hFF, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1},
    '{16'h8002, 16'h3030, 16'hFDF0, 3'd6, 8'h22, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0},
    '{16'h8002, 16'h3040, 16'hFDF0, 3'd6, 8'h22, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
    '{16'h8600, 16'h5000, 16'hEEEE, 3'd7, 8'h00, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_commit(output int cycles);
    cycles = 0;
    while (!commit && cycles < 200) begin
      @(negedge clk);
      cycles++;
    end
    if (commit) begin
      psr_r = psr_out;
      pc_r  = pc_out;
      r6_r  = sp_out;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    int cyc;
    int t0;
    logic [15:0] sp0, exp_psr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", {15'd0, busy}, 16'd0);
    check("R10 mem_req", {15'd0, mem_req}, 16'd0);
    check("R10 usp", usp_out, 16'h0000);
    check("R10 ssp", ssp_out, 16'h3000);

    for (int i = 0; i < 8; i++) begin
      case_t t;
      t = TBL[i];
      psr_r = t.psr; pc_r = t.pc; r6_r = t.r6;
      irq_prio = t.prio; irq_vec = t.vec; irq_req = t.req; irq_en = t.en;
      insn_done = t.done; lat = int'(t.lat);
      t0 = ntake;
      sp0 = t.psr[15] ? ssp_out : t.r6;
      @(negedge clk);
      insn_done = 0; irq_req = 0;
      if (!t.take) begin
        repeat (4) @(negedge clk);
        // R1 rejected request
        check("R1 no take", 16'(ntake - t0), 16'd0);
        check("R1 idle", {15'd0, busy}, 16'd0);
      end else begin
        check("R1 take", 16'(ntake - t0), 16'd1);
        wait_commit(cyc);
        check("R8 entry cycles", 16'(cyc), 16'(3 * (int'(t.lat) + 1)));
        exp_psr = {1'b0, t.psr[14:11], t.prio, t.psr[7:3], 3'b000};
        check("R2 psr", psr_r, exp_psr);
        check("R5 pc", pc_r, 16'h1000 | {8'h00, t.vec});
        check("R4 r6", r6_r, sp0 - 16'd2);
        check("R4 psr slot", mem[10'(sp0 - 16'd1)], t.psr);
        check("R4 pc slot", mem[10'(sp0 - 16'd2)], t.pc);
        if (t.psr[15]) check("R3 usp", usp_out, t.r6);
        @(negedge clk);
        check("R9 idle after commit", {15'd0, busy}, 16'd0);
        rti_start = 1;
        @(negedge clk);
        rti_start = 0;
        wait_commit(cyc);
        check("R8 return cycles", 16'(cyc), 16'(2 * (int'(t.lat) + 1)));
        check("R6 pc", pc_r, t.pc);
        check("R6 psr", psr_r, t.psr);
        check("R7 r6", r6_r, t.r6);
        @(negedge clk);
        check("R7 ssp", ssp_out, 16'h3000);
      end
    end

    // R3 privileged entry leaves saved user pointer alone
    psr_r = 16'h0000; pc_r = 16'h0700; r6_r = 16'h2E80;
    irq_prio = 3'd1; irq_vec = 8'h40; irq_req = 1; irq_en = 1; insn_done = 1; lat = 0;
    @(negedge clk);
    insn_done = 0; irq_req = 0;
    wait_commit(cyc);
    check("R3 usp kept", usp_out, 16'h5000 - 16'h0000 + 16'h9EEE);
    check("R3 r6 no swap", r6_r, 16'h2E7E);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule